// File: doc/BRIEF.md
# Time-of-day alarm comparator with don't-care fields

The block keeps three alarm bytes (hours, minutes, seconds) and compares them with the running time of a real-time clock. When the update engine reports that an update has finished, the block tests the freshly updated time against the alarm. If every field matches, it sets a sticky alarm flag. An alarm byte whose two most significant bits are both one is a don't-care and matches any value of its field. A status read clears the flag.

The block also gives the update engine a lookahead hint. While the engine says an update is coming soon, the block compares the alarm with the time that update will produce. It raises a pending output when they match, so the engine can hold its update-in-progress indication. The hint is recomputed every cycle from the alarm bytes as they stand. If the alarm is moved away, the hint drops within two cycles of the write, so the engine's indication cannot stay stuck high.

Top module: `alarm_match_top`

## Requirements
- R1: After reset the alarm flag and the pending output are 0, and all three alarm bytes are 0x00.
- R2: A cycle with `updateDone` high, in which every time field equals its alarm byte, sets `alarmFlag` from the next cycle on. The time fields are packed as `curTime[23:16]` hours, `[15:8]` minutes and `[7:0]` seconds.
- R3: An alarm byte with bits [7:6] equal to 2'b11 matches any value of its time field, whatever its low six bits hold.
- R4: If any field fails to match (exactly, or as a don't-care), an update leaves `alarmFlag` at 0.
- R5: `alarmFlag` changes only on an update cycle or a status read. A matching time without `updateDone` sets nothing, and a set flag stays set across later non-matching updates.
- R6: `statusRd` clears `alarmFlag` on the next cycle. If a read and a matching update fall in the same cycle, the flag ends up set, so the new event is not lost.
- R7: `alarmPending` is 1 in the cycle after one in which `updateSoon` is high and `nextTime` (same packing as `curTime`) matches the alarm. Otherwise it is 0.
- R8: If an alarm write makes the alarm stop matching `nextTime` while `updateSoon` stays high, `alarmPending` is 0 by the second cycle after the write cycle.
- R9: Alarm writes select the byte with `almWrSel`: 0 is seconds, 1 is minutes and 2 is hours. A write with `almWrSel` = 3 changes no alarm byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| almWrEn | input | 1 | Alarm byte write strobe |
| almWrSel | input | 2 | Alarm byte select (0 sec, 1 min, 2 hour) |
| almWrData | input | 8 | Alarm byte write data |
| curTime | input | 24 | Current time {hour, min, sec} |
| updateDone | input | 1 | Update has just completed; curTime holds the new time |
| nextTime | input | 24 | Time the coming update will produce |
| updateSoon | input | 1 | An update will occur within the hold window |
| statusRd | input | 1 | Status read; clears the alarm flag |
| alarmFlag | output | 1 | Sticky alarm-matched flag |
| alarmPending | output | 1 | Alarm will fire at the coming update |

## Verification
A corrupted alarm byte shows up at the first update whose time hits or misses the wrong value. The flag is one cycle late or missing, and every later update sees the same error. A bad don't-care decode shows when a field differs but the alarm byte is 0xC0, or when a low bit is set in a don't-care byte. A stale pending register shows two cycles after the alarm is moved: the hint is still high while `updateSoon` is held.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  localparam int ALM_FIELDS = 3;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic [ALM_FIELDS-1:0] wrField;
    logic                  setFlag;
    logic                  clrFlag;
  } almStrobes_t;
endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match #(
  parameter int FIELD_W = 8,
  parameter int WILD_BITS = 2
) (
  input  logic [FIELD_W-1:0] almByte,
  input  logic [FIELD_W-1:0] timeByte,
  output logic               hit
);
  localparam int TOP = FIELD_W - 1;
  logic isWild;

  always_comb begin
    isWild = &almByte[TOP -: WILD_BITS];
    hit    = isWild || (almByte == timeByte);
  end
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_match_pkg::*;
#(
  parameter int FIELDS = ALM_FIELDS
) (
  input  logic             almWrEn,
  input  logic [SEL_W-1:0] almWrSel,
  input  logic             updateDone,
  input  logic             statusRd,
  input  logic             nowMatch,
  output almStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    for (int i = 0; i < FIELDS; i++) begin
      strobes.wrField[i] = almWrEn && (almWrSel == SEL_W'(i));
    end
    // a fresh match wins over a simultaneous clear
    strobes.setFlag = updateDone && nowMatch;
    strobes.clrFlag = statusRd && !strobes.setFlag;
  end
endmodule

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_match_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int WILD_BITS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  almStrobes_t                   strobes,
  input  logic [FIELD_W-1:0]            wrData,
  input  logic [ALM_FIELDS*FIELD_W-1:0] curTime,
  input  logic [ALM_FIELDS*FIELD_W-1:0] nextTime,
  input  logic                          updateSoon,
  output logic                          nowMatch,
  output logic                          alarmFlag,
  output logic                          alarmPending
);
  logic [ALM_FIELDS-1:0] curHit;
  logic [ALM_FIELDS-1:0] nextHit;
  logic                  nextMatch;

  for (genvar i = 0; i < ALM_FIELDS; i++) begin : gField
    logic [FIELD_W-1:0] almByte;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        almByte <= '0;
      end else if (strobes.wrField[i]) begin
        almByte <= wrData;
      end
    end

    alarm_field_match #(.FIELD_W(FIELD_W), .WILD_BITS(WILD_BITS)) uCur (
      .almByte (almByte),
      .timeByte(curTime[i*FIELD_W +: FIELD_W]),
      .hit     (curHit[i])
    );

    alarm_field_match #(.FIELD_W(FIELD_W), .WILD_BITS(WILD_BITS)) uNext (
      .almByte (almByte),
      .timeByte(nextTime[i*FIELD_W +: FIELD_W]),
      .hit     (nextHit[i])
    );
  end

  always_comb begin
    nowMatch  = &curHit;
    nextMatch = &nextHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
    end else if (strobes.setFlag) begin
      alarmFlag <= 1'b1;
    end else if (strobes.clrFlag) begin
      alarmFlag <= 1'b0;
    end
  end

  // recomputed every cycle, so a moved alarm cannot leave it stuck
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmPending <= 1'b0;
    end else begin
      alarmPending <= updateSoon && nextMatch;
    end
  end
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_match_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int WILD_BITS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          almWrEn,
  input  logic [SEL_W-1:0]              almWrSel,
  input  logic [FIELD_W-1:0]            almWrData,
  input  logic [ALM_FIELDS*FIELD_W-1:0] curTime,
  input  logic                          updateDone,
  input  logic [ALM_FIELDS*FIELD_W-1:0] nextTime,
  input  logic                          updateSoon,
  input  logic                          statusRd,
  output logic                          alarmFlag,
  output logic                          alarmPending
);
  almStrobes_t strobes;
  logic        nowMatch;

  alarm_ctrl uCtrl (
    .almWrEn   (almWrEn),
    .almWrSel  (almWrSel),
    .updateDone(updateDone),
    .statusRd  (statusRd),
    .nowMatch  (nowMatch),
    .strobes   (strobes)
  );

  alarm_datapath #(.FIELD_W(FIELD_W), .WILD_BITS(WILD_BITS)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (almWrData),
    .curTime     (curTime),
    .nextTime    (nextTime),
    .updateSoon  (updateSoon),
    .nowMatch    (nowMatch),
    .alarmFlag   (alarmFlag),
    .alarmPending(alarmPending)
  );
endmodule

// File: rtl/alarm_match_checker.sv
module alarm_match_checker (
  input logic clk,
  input logic rstN,
  input logic updateDone,
  input logic updateSoon,
  input logic statusRd,
  input logic alarmFlag,
  input logic alarmPending
);
  // R2
  flag_rise_on_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(updateDone));

  // R6
  read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !updateDone) |=> !alarmFlag);

  // R5
  flag_quiet_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!updateDone && !statusRd) |=> $stable(alarmFlag));

  // R7
  pending_needs_soon_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updateSoon |=> !alarmPending);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!alarmFlag && !alarmPending));
endmodule

bind alarm_match_top alarm_match_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .updateDone  (updateDone),
  .updateSoon  (updateSoon),
  .statusRd    (statusRd),
  .alarmFlag   (alarmFlag),
  .alarmPending(alarmPending)
);

// File: tb/tb_alarm_match_top.sv
module tb_alarm_match_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        almWrEn = 1'b0;
  logic [1:0]  almWrSel = '0;
  logic [7:0]  almWrData = '0;
  logic [23:0] curTime = '0;
  logic        updateDone = 1'b0;
  logic [23:0] nextTime = '0;
  logic        updateSoon = 1'b0;
  logic        statusRd = 1'b0;
  logic        alarmFlag;
  logic        alarmPending;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_match_top dut (
    .clk(clk), .rstN(rstN), .almWrEn(almWrEn), .almWrSel(almWrSel),
    .almWrData(almWrData), .curTime(curTime), .updateDone(updateDone),
    .nextTime(nextTime), .updateSoon(updateSoon), .statusRd(statusRd),
    .alarmFlag(alarmFlag), .alarmPending(alarmPending)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wrAlarm(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    almWrEn = 1'b1; almWrSel = sel; almWrData = data;
    @(negedge clk);
    almWrEn = 1'b0;
  endtask

  task automatic setAlarm(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wrAlarm(2'd2, h);
    wrAlarm(2'd1, m);
    wrAlarm(2'd0, s);
  endtask

  // update pulse, optionally with a simultaneous status read
  task automatic update(input logic [23:0] t, input logic rd);
    @(negedge clk);
    curTime = t; updateDone = 1'b1; statusRd = rd;
    @(negedge clk);
    updateDone = 1'b0; statusRd = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 flag after reset", alarmFlag, 1'b0);
    chk("R1 pending after reset", alarmPending, 1'b0);
    update(24'h000000, 1'b0);
    chk("R1 alarm bytes zero match 00:00:00", alarmFlag, 1'b1);
    readStatus();
  endtask

  task automatic tExact();
    setAlarm(8'h12, 8'h34, 8'h56);
    update(24'h123455, 1'b0);
    chk("R4 seconds differ", alarmFlag, 1'b0);
    update(24'h123556, 1'b0);
    chk("R4 minutes differ", alarmFlag, 1'b0);
    update(24'h133456, 1'b0);
    chk("R4 hours differ", alarmFlag, 1'b0);
    update(24'h123456, 1'b0);
    chk("R2 exact match sets flag", alarmFlag, 1'b1);
    update(24'h123457, 1'b0);
    chk("R5 flag sticky across mismatch", alarmFlag, 1'b1);
    readStatus();
    chk("R6 read clears flag", alarmFlag, 1'b0);
  endtask

  task automatic tNoUpdate();
    @(negedge clk);
    curTime = 24'h123456;
    repeat (3) @(negedge clk);
    chk("R5 match without update ignored", alarmFlag, 1'b0);
  endtask

  task automatic tWild();
    setAlarm(8'h02, 8'hC0, 8'hC0);
    update(24'h020711, 1'b0);
    chk("R3 wildcard min/sec", alarmFlag, 1'b1);
    readStatus();
    update(24'h030711, 1'b0);
    chk("R3 hour still exact", alarmFlag, 1'b0);
    wrAlarm(2'd0, 8'hC5);
    update(24'h020059, 1'b0);
    chk("R3 wildcard ignores low bits", alarmFlag, 1'b1);
    readStatus();
    wrAlarm(2'd0, 8'h80);
    update(24'h020000, 1'b0);
    chk("R3 only 2'b11 is wild", alarmFlag, 1'b0);
  endtask

  task automatic tCollide();
    setAlarm(8'h05, 8'h06, 8'h07);
    update(24'h050607, 1'b1);
    chk("R6 set wins over read", alarmFlag, 1'b1);
    readStatus();
    chk("R6 later read clears", alarmFlag, 1'b0);
  endtask

  task automatic tPending();
    setAlarm(8'h02, 8'hC0, 8'hC0);
    @(negedge clk);
    nextTime = 24'h020400; updateSoon = 1'b1;
    @(negedge clk);
    chk("R7 pending on due alarm", alarmPending, 1'b1);
    updateSoon = 1'b0;
    @(negedge clk);
    chk("R7 pending needs updateSoon", alarmPending, 1'b0);
    nextTime = 24'h030400; updateSoon = 1'b1;
    @(negedge clk);
    chk("R7 no pending on mismatch", alarmPending, 1'b0);
    nextTime = 24'h020400;
    @(negedge clk);
    chk("R7 pending again", alarmPending, 1'b1);
    almWrEn = 1'b1; almWrSel = 2'd2; almWrData = 8'h03;
    @(negedge clk);
    almWrEn = 1'b0;
    @(negedge clk);
    chk("R8 pending drops after move", alarmPending, 1'b0);
    updateSoon = 1'b0;
  endtask

  task automatic tSel3();
    setAlarm(8'h02, 8'hC0, 8'hC0);
    wrAlarm(2'd3, 8'h17);
    update(24'h021010, 1'b0);
    chk("R9 select 3 ignored", alarmFlag, 1'b1);
    readStatus();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tExact();
    tNoUpdate();
    tWild();
    tCollide();
    tPending();
    tSel3();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule